// File: doc/BRIEF.md
# Externally Clocked Synchronous Shift Slave

This block is a byte-wide synchronous serial port that only ever acts as a slave. An external master drives the shift clock. The port sends one bit per clock period on its transmit line and takes one bit per clock period from its receive line, least significant bit first. Transmit bits change after each falling shift-clock edge. Receive bits are captured on each rising shift-clock edge. The shift clock idles high.

The shift clock and the receive line are both brought into the system clock domain through synchronizer chains of equal depth. Edges of the shift clock are then detected in that domain. Each direction is double buffered. A parallel holding register feeds the transmit shifter, and a parallel receive register takes each completed byte from the receive shifter. The controlling logic writes bytes into the holding register and reads completed bytes from the receive register. It is guided by three flags: transmit-empty, receive-ready and overrun.

An external protocol must keep the two ends from transmitting at the same time. This block does not handle that.

Top module: `sync_shift_slave`

## Requirements
- R1: After reset, `txdOut` is 1, `txEmpty` is 1, `rxReady` is 0, `overrun` is 0 and `rxData` is 0.
- R2: A byte written to the holding register goes out on `txdOut` one bit per shift-clock period. The order is bit 0 first and bit 7 last. Each bit appears after a synchronized falling edge and is held through the following rising edge.
- R3: `rxdIn` is sampled on each synchronized rising edge. The first bit sampled lands in bit 0 of the byte. After the 8th rising edge, the assembled byte appears on `rxData` and `rxReady` goes to 1.
- R4: A one-cycle `rxRdEn` pulse clears `rxReady` and `overrun`.
- R5: `txEmpty` goes to 0 on a write. It returns to 1 when the holding register moves into the shifter, which happens on the first falling edge of that byte.
- R6: A write made while `txEmpty` is 0 is ignored, and the byte already held is the one sent.
- R7: When a byte boundary is reached and no byte is held, `txdOut` is 1 for the whole next byte period.
- R8: `overrun` goes to 1 when a byte completes while `rxReady` is still 1. `rxData` then shows the newest byte.
- R9: A byte written during a transfer is sent in the very next byte period, with no idle bit between the two bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclkIn | input | 1 | Shift clock from the external master; idles high |
| rxdIn | input | 1 | Serial receive data |
| txdOut | output | 1 | Serial transmit data; idles high |
| txWrEn | input | 1 | Write strobe for the transmit holding register |
| txData | input | 8 | Byte to be written into the holding register |
| txEmpty | output | 1 | Holding register free |
| rxRdEn | input | 1 | Read strobe for the receive register |
| rxData | output | 8 | Last completed received byte |
| rxReady | output | 1 | Unread byte present in `rxData` |
| overrun | output | 1 | A byte completed before the previous one was read |

## Verification
The assertions assume the shift clock is much slower than the system clock. Each shift-clock level must last more than the synchronizer depth plus one system cycle, so that every master edge yields exactly one detected edge. The assertions also assume that `rxdIn` changes together with the falling shift-clock edge, and not near the rising edge.

The stimulus keeps to these assumptions. It holds each shift-clock level for four system clocks, and it changes the receive line only in the same cycle that the shift clock falls. Reads and writes are issued between shift-clock edges. This avoids the case where a read lands in the same cycle as a byte completion, where completion takes priority.

// File: rtl/sss_pkg.sv
package sss_pkg;
  typedef struct packed {
    logic txLoad;    // holding register moves into the shifter, bit 0 driven
    logic txShift;   // next bit of the current byte driven
    logic txIdle;    // byte boundary with nothing held: drive idle level
    logic rxShift;   // one receive bit captured
    logic rxCommit;  // last bit of a byte captured, publish it
  } shiftStrobes_t;
endpackage

// File: rtl/sss_ctrl.sv
module sss_ctrl
  import sss_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sclkIn,
  input  logic          rxdIn,
  input  logic          holdFull,
  output shiftStrobes_t strb,
  output logic          rxdSampled
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [SYNC_STAGES-1:0] sclkPipe;
  logic [SYNC_STAGES-1:0] rxdPipe;
  logic                   sclkLast;
  logic                   sclkNow;
  logic                   riseEvt;
  logic                   fallEvt;
  logic [CNT_W-1:0]       txCnt;
  logic [CNT_W-1:0]       rxCnt;

  // Equal-depth synchronizers keep data aligned with the clock it belongs to
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkPipe <= '1;
      rxdPipe  <= '1;
      sclkLast <= 1'b1;
    end else begin
      sclkPipe <= {sclkPipe[SYNC_STAGES-2:0], sclkIn};
      rxdPipe  <= {rxdPipe[SYNC_STAGES-2:0], rxdIn};
      sclkLast <= sclkNow;
    end
  end

  assign sclkNow    = sclkPipe[SYNC_STAGES-1];
  assign rxdSampled = rxdPipe[SYNC_STAGES-1];
  assign riseEvt    = sclkNow & ~sclkLast;
  assign fallEvt    = ~sclkNow & sclkLast;

  always_comb begin
    strb          = '0;
    strb.txLoad   = fallEvt && (txCnt == '0) && holdFull;
    strb.txIdle   = fallEvt && (txCnt == '0) && !holdFull;
    strb.txShift  = fallEvt && (txCnt != '0);
    strb.rxShift  = riseEvt;
    strb.rxCommit = riseEvt && (rxCnt == LAST_BIT);
  end

  // txCnt: bits of the current byte already driven (0 = at a byte boundary)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txCnt <= '0;
      rxCnt <= '0;
    end else begin
      if (strb.txLoad) begin
        txCnt <= CNT_W'(1);
      end else if (strb.txShift) begin
        txCnt <= (txCnt == LAST_BIT) ? '0 : txCnt + CNT_W'(1);
      end
      if (strb.rxShift) begin
        rxCnt <= (rxCnt == LAST_BIT) ? '0 : rxCnt + CNT_W'(1);
      end
    end
  end

  // R2: at most one transmit action per detected edge
  a_r2_tx_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.txLoad, strb.txShift, strb.txIdle}));

  // R3: after publishing a byte the receive count restarts
  a_r3_commit_restarts: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxCommit |=> (rxCnt == '0));

  // R2: rising and falling edges never coincide
  a_r2_edges_disjoint: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rxShift && (strb.txLoad || strb.txShift || strb.txIdle)));
endmodule

// File: rtl/sss_dpath.sv
module sss_dpath
  import sss_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  shiftStrobes_t     strb,
  input  logic              rxdSampled,
  input  logic              txWrEn,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxRdEn,
  output logic              txdOut,
  output logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              overrun,
  output logic              holdFull
);
  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] txShiftReg;
  logic [DATA_W-1:0] rxShiftReg;
  logic [DATA_W-1:0] rxNext;

  assign rxNext = {rxdSampled, rxShiftReg[DATA_W-1:1]};

  // Transmit side: holding register and output shifter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg    <= '0;
      holdFull   <= 1'b0;
      txShiftReg <= '1;
      txdOut     <= 1'b1;
    end else begin
      if (strb.txLoad) begin
        txdOut     <= holdReg[0];
        txShiftReg <= {1'b1, holdReg[DATA_W-1:1]};
        holdFull   <= 1'b0;
      end else if (strb.txShift) begin
        txdOut     <= txShiftReg[0];
        txShiftReg <= {1'b1, txShiftReg[DATA_W-1:1]};
      end else if (strb.txIdle) begin
        txdOut <= 1'b1;
      end
      // load requires a full register, a write requires an empty one
      if (txWrEn && !holdFull) begin
        holdReg  <= txData;
        holdFull <= 1'b1;
      end
    end
  end

  // Receive side: input shifter and published register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShiftReg <= '0;
      rxData     <= '0;
      rxReady    <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      if (strb.rxShift) rxShiftReg <= rxNext;
      if (strb.rxCommit) begin
        rxData  <= rxNext;
        rxReady <= 1'b1;
        overrun <= overrun | rxReady;
      end else if (rxRdEn) begin
        rxReady <= 1'b0;
        overrun <= 1'b0;
      end
    end
  end

  // R3: a completed byte is always flagged
  a_r3_ready_after_commit: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxCommit |=> rxReady);

  // R4: a read with no completing byte clears both flags
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (rxRdEn && !strb.rxCommit) |=> (!rxReady && !overrun));

  // R8: overrun only rises on top of an unread byte
  a_r8_overrun_needs_ready: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(rxReady));

  // R5: the holding register frees up when its byte starts
  a_r5_empty_after_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.txLoad |=> !holdFull);

  // R6: a write into a full holding register changes nothing
  a_r6_full_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (txWrEn && holdFull) |=> $stable(holdReg));

  // R7: boundary with nothing to send drives the idle level
  a_r7_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    strb.txIdle |=> txdOut);

  // R2: the line only moves on a transmit strobe
  a_r2_txd_moves_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.txLoad || strb.txShift || strb.txIdle) |=> $stable(txdOut));
endmodule

// File: rtl/sync_shift_slave.sv
module sync_shift_slave
  import sss_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              rxdIn,
  output logic              txdOut,
  input  logic              txWrEn,
  input  logic [DATA_W-1:0] txData,
  output logic              txEmpty,
  input  logic              rxRdEn,
  output logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              overrun
);
  shiftStrobes_t strb;
  logic          rxdSampled;
  logic          holdFull;

  sss_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .sclkIn     (sclkIn),
    .rxdIn      (rxdIn),
    .holdFull   (holdFull),
    .strb       (strb),
    .rxdSampled (rxdSampled)
  );

  sss_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .rxdSampled (rxdSampled),
    .txWrEn     (txWrEn),
    .txData     (txData),
    .rxRdEn     (rxRdEn),
    .txdOut     (txdOut),
    .rxData     (rxData),
    .rxReady    (rxReady),
    .overrun    (overrun),
    .holdFull   (holdFull)
  );

  assign txEmpty = !holdFull;
endmodule

// File: tb/sim_sync_shift_slave.sv
module sim_sync_shift_slave;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclkIn = 1'b1;
  logic       rxdIn = 1'b1;
  logic       txdOut;
  logic       txWrEn = 1'b0;
  logic [7:0] txData = '0;
  logic       txEmpty;
  logic       rxRdEn = 1'b0;
  logic [7:0] rxData;
  logic       rxReady;
  logic       overrun;

  int nVec = 0;
  int nBad = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  sync_shift_slave u0 (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .rxdIn(rxdIn), .txdOut(txdOut),
    .txWrEn(txWrEn), .txData(txData), .txEmpty(txEmpty), .rxRdEn(rxRdEn),
    .rxData(rxData), .rxReady(rxReady), .overrun(overrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wrTx(input logic [7:0] v);
    @(negedge clk); txWrEn = 1'b1; txData = v;
    @(negedge clk); txWrEn = 1'b0;
  endtask

  task automatic rdRx();
    @(negedge clk); rxRdEn = 1'b1;
    @(negedge clk); rxRdEn = 1'b0;
  endtask

  // One byte period; each shift-clock level lasts four system clocks.
  task automatic xfer(input logic [7:0] rxB, input bit midWr, input logic [7:0] midVal,
                      output logic [7:0] got);
    for (int i = 0; i < 8; i++) begin
      sclkIn = 1'b0; rxdIn = rxB[i];
      repeat (4) @(posedge clk);
      @(negedge clk);
      got[i] = txdOut;
      if (midWr && i == 0) begin
        chk("R5 empty once byte loaded", txEmpty, 1);
        txWrEn = 1'b1; txData = midVal;
        @(negedge clk); txWrEn = 1'b0;
        chk("R5 full after mid write", txEmpty, 0);
      end
      sclkIn = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    logic [7:0] rxB;
    repeat (5) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 txdOut", txdOut, 1);
    chk("R1 txEmpty", txEmpty, 1);
    chk("R1 rxReady", rxReady, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 rxData", rxData, 0);

    // Exhaustive sweep over every transmit byte, with a derived receive byte
    for (int v = 0; v < 256; v++) begin
      rxB = 8'(v * 37 + 91);
      wrTx(8'(v));
      chk("R5 write fills holding", txEmpty, 0);
      xfer(rxB, 1'b0, 8'h00, got);
      chk("R2 tx byte LSB first", got, 32'(v));
      chk("R3 rx byte", rxData, rxB);
      chk("R3 rxReady set", rxReady, 1);
      chk("R5 empty after transfer", txEmpty, 1);
      chk("R8 no overrun", overrun, 0);
      rdRx();
      chk("R4 read clears ready", rxReady, 0);
    end

    // R7 idle high with nothing held
    xfer(8'h3C, 1'b0, 8'h00, got);
    chk("R7 idle line", got, 8'hFF);
    chk("R3 rx during idle tx", rxData, 8'h3C);
    rdRx();

    // R6 write while full ignored
    wrTx(8'hA5);
    wrTx(8'h0F);
    chk("R6 still full", txEmpty, 0);
    xfer(8'h11, 1'b0, 8'h00, got);
    chk("R6 first byte kept", got, 8'hA5);
    rdRx();
    xfer(8'h22, 1'b0, 8'h00, got);
    chk("R6 ignored byte never sent", got, 8'hFF);
    rdRx();

    // R9 back-to-back bytes, no read in between gives R8 overrun
    wrTx(8'h81);
    xfer(8'hC3, 1'b1, 8'h7E, got);
    chk("R9 first byte", got, 8'h81);
    chk("R8 no overrun yet", overrun, 0);
    xfer(8'h5D, 1'b0, 8'h00, got);
    chk("R9 second byte follows at once", got, 8'h7E);
    chk("R8 overrun set", overrun, 1);
    chk("R8 newest byte kept", rxData, 8'h5D);
    rdRx();
    chk("R4 read clears overrun", overrun, 0);
    chk("R4 read clears ready", rxReady, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule